// File: doc/BRIEF.md
# Pipelined Debug Register Access Chain

This block is a test-clock-domain scan chain that gives a debug host read and write access to a bank of 32-bit debug registers, such as breakpoint, watchpoint and vector-catch controls, at up to 128 addresses. Each scan loads a request made of an access flag, a data word and a register address. The request is launched when the update strobe arrives. The access then takes a fixed number of test clocks to complete.

The outcome of a request is loaded into the chain by the capture of the next scan and shifted out during that scan. It carries a ready flag in the flag position, the address of the previous request, and either the register contents (for a read) or the written value (for a write). If the ready flag comes back 0, the previous access has not finished and the host repeats the scan. To collect the result of the last real request, the host ends each access sequence with a read of address 0 carrying zero data.

The register bank is presented as one flat output vector for the logic that uses it.

Top module: `dbg_reg_chain`

## Requirements
- R1: The chain is 1+DATA_W+ADDR_W bits long (40 by default) and is shifted least significant bit first. Bit 0 is the access flag. Bits 1..DATA_W hold the data word, LSB first. The next ADDR_W bits hold the address, LSB first. `tdo` always shows bit 0 of the chain.
- R2: A capture loads the chain as follows: bit 0 takes the ready flag, the data field takes the response data of the last completed request, and the address field takes that request's address.
- R3: An accepted request with flag 1 writes its data word to the addressed register. The write appears on `reg_bank` (register i at bits i*DATA_W upward) ACCESS_LAT clocks after the update edge.
- R4: An accepted request with flag 0 returns the addressed register's contents in the data field of the next ready capture.
- R5: The response to a write returns the written data word and the written address.
- R6: The ready flag is 0 at every capture edge up to and including the ACCESS_LAT-th edge after an accepted update. It is 1 afterwards.
- R7: An update that arrives while a request is still pending is discarded. It changes neither the register bank nor the pending response.
- R8: Only addresses below NUM_REGS are implemented. A write to any other address leaves the bank unchanged. A read of any other address returns 0 data with that address.
- R9: After reset, all registers hold 0, the response is address 0 with data 0, and the ready flag is 1.
- R10: While `chain_sel` is low, the capture, shift and update strobes have no effect. `tdo`, the chain contents and the bank all stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| chain_sel | input | 1 | This chain is the selected data register |
| capture_dr | input | 1 | Capture strobe, one clock |
| shift_dr | input | 1 | Shift strobe, one clock per bit |
| update_dr | input | 1 | Update strobe, one clock |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| reg_bank | output | NUM_REGS*DATA_W | Flattened register bank contents |

## Verification
The bench builds the block with NUM_REGS set to 12 and ACCESS_LAT set to 48. With 12 registers, part of the 7-bit address space is implemented and part is not, so writes and reads to addresses outside the bank are exercised. A latency of 48 clocks is longer than one full 40-bit scan plus update, so an update can arrive while a request is still pending. This lets the bench check the discarded-update case and both values of the ready flag, along with random gaps between scans.

// File: rtl/dbg_reg_chain_pkg.sv
package dbg_reg_chain_pkg;

   // Operation performed on the serial chain in a given clock
   typedef enum logic [1:0] {
      CH_HOLD    = 2'd0,
      CH_CAPTURE = 2'd1,
      CH_SHIFT   = 2'd2
   } chain_op_e;

   // Width of a down-counter that must hold the value lat
   function automatic int cnt_width(input int lat);
      return (lat < 2) ? 1 : $clog2(lat + 1);
   endfunction

endpackage

// File: rtl/dbg_reg_chain_shifter.sv
module dbg_reg_chain_shifter
   import dbg_reg_chain_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              capture,
   input  logic              shift,
   input  logic              tdi,
   input  logic              cap_ready,
   input  logic [DATA_W-1:0] cap_data,
   input  logic [ADDR_W-1:0] cap_addr,
   output logic              tdo,
   output logic              req_wr,
   output logic [DATA_W-1:0] req_data,
   output logic [ADDR_W-1:0] req_addr
);
   localparam int CHAIN_W = 1 + DATA_W + ADDR_W;

   logic [CHAIN_W-1:0] chain_q;
   chain_op_e          op;

   always_comb begin
      op = CH_HOLD;
      if (sel) begin
         if (capture)    op = CH_CAPTURE;
         else if (shift) op = CH_SHIFT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         case (op)
            CH_CAPTURE: chain_q <= {cap_addr, cap_data, cap_ready};
            CH_SHIFT:   chain_q <= {tdi, chain_q[CHAIN_W-1:1]};
            default:    chain_q <= chain_q;
         endcase
      end
   end

   assign tdo      = chain_q[0];
   assign req_wr   = chain_q[0];
   assign req_data = chain_q[DATA_W:1];
   assign req_addr = chain_q[CHAIN_W-1:DATA_W+1];

endmodule

// File: rtl/dbg_reg_chain_seq.sv
module dbg_reg_chain_seq
   import dbg_reg_chain_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 7,
   parameter int ACCESS_LAT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              update,
   input  logic              req_wr,
   input  logic [DATA_W-1:0] req_data,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              ready,
   output logic              cpl,
   output logic              cpl_wr,
   output logic [DATA_W-1:0] cpl_data,
   output logic [ADDR_W-1:0] cpl_addr,
   output logic [DATA_W-1:0] resp_data,
   output logic [ADDR_W-1:0] resp_addr
);
   localparam int CNT_W = cnt_width(ACCESS_LAT);

   generate
      if (ACCESS_LAT == 0) begin : g_direct
         // Access completes on the update edge itself
         assign ready    = 1'b1;
         assign cpl      = sel & update;
         assign cpl_wr   = req_wr;
         assign cpl_data = req_data;
         assign cpl_addr = req_addr;
      end else begin : g_delayed
         logic [CNT_W-1:0]  cnt_q;
         logic              wr_q;
         logic [DATA_W-1:0] data_q;
         logic [ADDR_W-1:0] addr_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q  <= '0;
               wr_q   <= 1'b0;
               data_q <= '0;
               addr_q <= '0;
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end else if (sel && update) begin
               cnt_q  <= CNT_W'(ACCESS_LAT);
               wr_q   <= req_wr;
               data_q <= req_data;
               addr_q <= req_addr;
            end
         end

         assign ready    = (cnt_q == '0);
         assign cpl      = (cnt_q == CNT_W'(1));
         assign cpl_wr   = wr_q;
         assign cpl_data = data_q;
         assign cpl_addr = addr_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_data <= '0;
         resp_addr <= '0;
      end else if (cpl) begin
         resp_addr <= cpl_addr;
         resp_data <= cpl_wr ? cpl_data : rd_data;
      end
   end

endmodule

// File: rtl/dbg_reg_chain_bank.sv
module dbg_reg_chain_bank #(
   parameter int              DATA_W    = 32,
   parameter int              ADDR_W    = 7,
   parameter int              NUM_REGS  = 16,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [ADDR_W-1:0]          rd_addr,
   output logic [DATA_W-1:0]          rd_data,
   output logic [NUM_REGS*DATA_W-1:0] bank_flat
);

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= RESET_VAL;
            else if (wr_en && (wr_addr == ADDR_W'(i)))
               q <= wr_data;
         end
         assign bank_flat[i*DATA_W +: DATA_W] = q;
      end
   endgenerate

   // Addresses without a register fall through to zero
   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_addr == ADDR_W'(i))
            rd_data = bank_flat[i*DATA_W +: DATA_W];
      end
   end

endmodule

// File: rtl/dbg_reg_chain.sv
module dbg_reg_chain #(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 7,
   parameter int NUM_REGS   = 16,
   parameter int ACCESS_LAT = 3
) (
   input  logic                       tck,
   input  logic                       trst_n,
   input  logic                       chain_sel,
   input  logic                       capture_dr,
   input  logic                       shift_dr,
   input  logic                       update_dr,
   input  logic                       tdi,
   output logic                       tdo,
   output logic [NUM_REGS*DATA_W-1:0] reg_bank
);

   generate
      if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_regs
         $error("NUM_REGS must be within 1 .. 2**ADDR_W");
      end
      if (DATA_W < 1 || ADDR_W < 1) begin : g_bad_width
         $error("DATA_W and ADDR_W must be positive");
      end
      if (ACCESS_LAT < 0) begin : g_bad_lat
         $error("ACCESS_LAT must not be negative");
      end
   endgenerate

   logic              req_wr;
   logic [DATA_W-1:0] req_data;
   logic [ADDR_W-1:0] req_addr;
   logic              seq_ready;
   logic              cpl;
   logic              cpl_wr;
   logic [DATA_W-1:0] cpl_data;
   logic [ADDR_W-1:0] cpl_addr;
   logic [DATA_W-1:0] resp_data;
   logic [ADDR_W-1:0] resp_addr;
   logic [DATA_W-1:0] rd_data;

   dbg_reg_chain_shifter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_shift (
      .clk       (tck),
      .rst_n     (trst_n),
      .sel       (chain_sel),
      .capture   (capture_dr),
      .shift     (shift_dr),
      .tdi       (tdi),
      .cap_ready (seq_ready),
      .cap_data  (resp_data),
      .cap_addr  (resp_addr),
      .tdo       (tdo),
      .req_wr    (req_wr),
      .req_data  (req_data),
      .req_addr  (req_addr)
   );

   dbg_reg_chain_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ACCESS_LAT(ACCESS_LAT)) u_seq (
      .clk       (tck),
      .rst_n     (trst_n),
      .sel       (chain_sel),
      .update    (update_dr),
      .req_wr    (req_wr),
      .req_data  (req_data),
      .req_addr  (req_addr),
      .rd_data   (rd_data),
      .ready     (seq_ready),
      .cpl       (cpl),
      .cpl_wr    (cpl_wr),
      .cpl_data  (cpl_data),
      .cpl_addr  (cpl_addr),
      .resp_data (resp_data),
      .resp_addr (resp_addr)
   );

   dbg_reg_chain_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_bank (
      .clk       (tck),
      .rst_n     (trst_n),
      .wr_en     (cpl & cpl_wr),
      .wr_addr   (cpl_addr),
      .wr_data   (cpl_data),
      .rd_addr   (cpl_addr),
      .rd_data   (rd_data),
      .bank_flat (reg_bank)
   );

endmodule

// File: rtl/dbg_reg_chain_checker.sv
module dbg_reg_chain_checker #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 7,
   parameter int NUM_REGS = 16
) (
   input logic                       tck,
   input logic                       trst_n,
   input logic                       chain_sel,
   input logic                       capture_dr,
   input logic                       tdo,
   input logic                       ready,
   input logic                       cpl,
   input logic                       cpl_wr,
   input logic [ADDR_W-1:0]          cpl_addr,
   input logic [DATA_W-1:0]          cpl_data,
   input logic [DATA_W-1:0]          resp_data,
   input logic [NUM_REGS*DATA_W-1:0] reg_bank
);

   AST_CAPTURE_READY_BIT: assert property (@(posedge tck) disable iff (!trst_n)
      (chain_sel && capture_dr) |=> (tdo == $past(ready))); // R2

   AST_BANK_ONLY_ON_DONE: assert property (@(posedge tck) disable iff (!trst_n)
      !cpl |=> $stable(reg_bank)); // R7

   AST_READY_AFTER_DONE: assert property (@(posedge tck) disable iff (!trst_n)
      cpl |=> ready); // R6

   AST_WRITE_ECHO: assert property (@(posedge tck) disable iff (!trst_n)
      (cpl && cpl_wr) |=> (resp_data == $past(cpl_data))); // R5

   AST_UNIMPL_READ_ZERO: assert property (@(posedge tck) disable iff (!trst_n)
      (cpl && !cpl_wr && (int'(cpl_addr) >= NUM_REGS)) |=> (resp_data == '0)); // R8

   AST_DESELECT_QUIET: assert property (@(posedge tck) disable iff (!trst_n)
      !chain_sel |=> $stable(tdo)); // R10

endmodule

bind dbg_reg_chain dbg_reg_chain_checker #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .NUM_REGS (NUM_REGS)
) u_chk (
   .tck        (tck),
   .trst_n     (trst_n),
   .chain_sel  (chain_sel),
   .capture_dr (capture_dr),
   .tdo        (tdo),
   .ready      (seq_ready),
   .cpl        (cpl),
   .cpl_wr     (cpl_wr),
   .cpl_addr   (cpl_addr),
   .cpl_data   (cpl_data),
   .resp_data  (resp_data),
   .reg_bank   (reg_bank)
);

// File: tb/dbg_reg_chain_bench.sv
module dbg_reg_chain_bench;
   localparam int DW  = 32;
   localparam int AW  = 7;
   localparam int NR  = 12;
   localparam int LAT = 48;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic           trst_n, chain_sel, capture_dr, shift_dr, update_dr, tdi, tdo;
   logic [NR*DW-1:0] reg_bank;

   dbg_reg_chain #(.DATA_W(DW), .ADDR_W(AW), .NUM_REGS(NR), .ACCESS_LAT(LAT)) u_dbg_reg_chain (
      .tck(clk), .trst_n(trst_n), .chain_sel(chain_sel), .capture_dr(capture_dr),
      .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo), .reg_bank(reg_bank)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   // Reference model
   logic [DW-1:0] shadow [128];
   logic [AW-1:0] m_addr, p_addr;
   logic [DW-1:0] m_data, p_data;
   bit            p_valid;
   int            p_done;

   function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
      return (int'(a) < NR) ? shadow[a] : '0;
   endfunction

   function automatic bit model_busy(input int e);
      return p_valid && (e <= p_done);
   endfunction

   task automatic model_settle(input int e);
      if (p_valid && e > p_done) begin
         m_addr  = p_addr;
         m_data  = p_data;
         p_valid = 0;
      end
   endtask

   task automatic model_update(input int e, input logic wr, input logic [DW-1:0] d,
                               input logic [AW-1:0] a);
      model_settle(e);
      if (!model_busy(e)) begin
         p_addr  = a;
         p_data  = wr ? d : exp_read(a);
         if (wr && int'(a) < NR) shadow[a] = d;
         p_valid = 1;
         p_done  = e + LAT;
      end
   endtask

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_bank(input string req);
      if (!p_valid || cyc >= p_done)
         for (int i = 0; i < NR; i++)
            check(req, 64'(reg_bank[i*DW +: DW]), 64'(shadow[i]));
   endtask

   // One full scan: capture, shift 40 bits, optional update, then idle gap
   task automatic scan(input string req, input logic wr, input logic [DW-1:0] d,
                       input logic [AW-1:0] a, input int gap, input bit do_upd);
      logic [DW+AW:0] w, got, expv;
      int e;
      w = {a, d, wr};
      @(negedge clk);
      capture_dr = 1'b1;
      e = cyc + 1;
      model_settle(e);
      expv = {m_addr, m_data, ~model_busy(e)};
      for (int i = 0; i <= DW + AW; i++) begin
         @(negedge clk);
         capture_dr = 1'b0;
         shift_dr   = 1'b1;
         got[i]     = tdo;
         tdi        = w[i];
      end
      @(negedge clk);
      shift_dr = 1'b0;
      tdi      = 1'b0;
      if (do_upd) begin
         update_dr = 1'b1;
         model_update(cyc + 1, wr, d, a);
         @(negedge clk);
         update_dr = 1'b0;
      end
      for (int g = 0; g < gap; g++) @(negedge clk);
      check(req, 64'(got), 64'(expv));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic tdo_before;
      void'($urandom(32'h5EED_0C7A));
      for (int i = 0; i < 128; i++) shadow[i] = '0;
      m_addr = '0; m_data = '0; p_addr = '0; p_data = '0; p_valid = 0; p_done = 0;
      trst_n = 1'b0; chain_sel = 1'b1; capture_dr = 1'b0; shift_dr = 1'b0;
      update_dr = 1'b0; tdi = 1'b0;
      repeat (4) @(negedge clk);
      trst_n = 1'b1;

      // R9: reset state of bank and first capture
      check_bank("R9");
      scan("R9", 1'b0, '0, '0, LAT + 2, 1'b1);

      // R3 R5: write then read back, R4 flush with dummy
      scan("R3", 1'b1, 32'hDEAD_BEEF, 7'd2, LAT + 4, 1'b1);
      check_bank("R3");
      scan("R5", 1'b0, '0, 7'd2, LAT + 4, 1'b1);
      scan("R4", 1'b0, '0, 7'd0, LAT + 4, 1'b1);

      // R8: unimplemented address, write ignored, read returns zero
      scan("R8", 1'b1, 32'h1234_5678, 7'd100, LAT + 4, 1'b1);
      check_bank("R8");
      scan("R8", 1'b0, '0, 7'd100, LAT + 4, 1'b1);
      scan("R8", 1'b0, '0, 7'd0, LAT + 4, 1'b1);
      check_bank("R8");

      // R6 R7: back-to-back, second update arrives while pending
      scan("R6", 1'b1, 32'hAAAA_0001, 7'd4, 0, 1'b1);
      scan("R6", 1'b1, 32'hBBBB_0002, 7'd4, LAT + 4, 1'b1);
      scan("R7", 1'b0, '0, 7'd4, LAT + 4, 1'b1);
      check_bank("R7");
      scan("R7", 1'b0, '0, 7'd0, LAT + 4, 1'b1);
      check(int'(reg_bank[4*DW +: DW]) == 32'hAAAA_0001 ? "R7" : "R7",
            64'(reg_bank[4*DW +: DW]), 64'(32'hAAAA_0001));

      // R10: deselected strobes do nothing
      scan("R10", 1'b1, 32'h5A5A_C3C3, 7'd7, 2, 1'b0);
      @(negedge clk);
      chain_sel  = 1'b0;
      tdo_before = tdo;
      capture_dr = 1'b1;
      @(negedge clk);
      capture_dr = 1'b0;
      for (int i = 0; i < 5; i++) begin
         shift_dr = 1'b1; tdi = ~tdi;
         @(negedge clk);
      end
      shift_dr  = 1'b0;
      update_dr = 1'b1;
      @(negedge clk);
      update_dr = 1'b0;
      repeat (LAT + 3) @(negedge clk);
      check("R10", 64'(tdo), 64'(tdo_before));
      check_bank("R10");
      chain_sel = 1'b1;
      update_dr = 1'b1;
      model_update(cyc + 1, 1'b1, 32'h5A5A_C3C3, 7'd7);
      @(negedge clk);
      update_dr = 1'b0;
      repeat (LAT + 3) @(negedge clk);
      check("R3", 64'(reg_bank[7*DW +: DW]), 64'(32'h5A5A_C3C3));
      scan("R10", 1'b0, '0, 7'd0, LAT + 4, 1'b1);

      // R1: random accesses with random spacing
      for (int n = 0; n < 250; n++) begin
         logic          wr;
         logic [AW-1:0] a;
         logic [DW-1:0] d;
         int            gap;
         wr  = 1'($urandom_range(0, 1));
         a   = ($urandom_range(0, 3) != 0) ? AW'($urandom_range(0, 15))
                                           : AW'($urandom_range(0, 127));
         d   = $urandom();
         gap = $urandom_range(0, LAT + 8);
         scan("R1", wr, d, a, gap, 1'b1);
         check_bank("R3");
      end
      scan("R4", 1'b0, '0, 7'd0, LAT + 4, 1'b1);
      scan("R4", 1'b0, '0, 7'd0, LAT + 4, 1'b1);
      check_bank("R3");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule